// File: doc/BRIEF.md
# BLDC Hall Commutation Gate Logic

This block turns three Hall-effect sensor lines into gate-enable signals for a three-phase bridge with one high-side and one low-side switch per phase. The Hall lines are synchronized to the clock. The synchronized code then selects one phase to source current and one phase to sink it, and a direction input can reverse that choice. A PWM input chops the selected pair. Two controls set what happens during the off part of each PWM cycle: decay mode picks which switches open, and synchronous rectification optionally closes the complementary switches so that current does not flow through the body diodes.

Three conditions override normal commutation, in this order: a disable input, then coast (either an external coast request or an impossible Hall code), then brake. A per-phase guard makes sure the two switches of one phase are never on together. It also inserts a dead time before any switch turns on. A tachometer output gives a fixed-width pulse on every change of the synchronized Hall code.

Top module: `bldc_commutator`

## Requirements
- R1: While `disable_in` is high, all six gate outputs go low on the next clock, whatever the state of brake, PWM and the Hall lines.
- R2: When `coast_req` is high, or the synchronized Hall code is 000 or 111, all six gates go low. `hall_bad` is high exactly while the synchronized code is 000 or 111, with one register of delay.
- R3: With `brake_n` low and neither disable nor coast active, all high-side gates are off and all low-side gates turn on.
- R4: Bit order is code = {hall_in[2],hall_in[1],hall_in[0]} and gate bit 0/1/2 = phase A/B/C. With `dir_rev` low and `pwm_on` high, the codes drive these gates: 101 → A high with B low; 100 → A high with C low; 110 → B high with C low; 010 → B high with A low; 011 → C high with A low; 001 → C high with B low.
- R5: With `dir_rev` high, each code drives the opposite pair: the phase that R4 drives high is driven low, and the phase that R4 drives low is driven high.
- R6: In slow decay (`slow_decay` high) with `pwm_on` low, only the selected high-side gate opens and the selected low-side gate stays on.
- R7: In fast decay (`slow_decay` low) with `pwm_on` low, both selected gates open.
- R8: With `sync_rect` high and `pwm_on` low, the complement of every opened selected switch is turned on. With `sync_rect` low, those complements stay off.
- R9: A high and a low gate of the same phase are never on together. A gate may turn on only after both gates of its phase have been off for at least DEAD_CYC clocks.
- R10: Every change of the synchronized Hall code starts `tach_pulse` on the next clock and holds it high for CLK_MHZ*TACH_NS/1000 clocks. A further change restarts that count.
- R11: Each Hall line passes through SYNC_STAGES flops, so a Hall change reaches the gate outputs SYNC_STAGES+1 clocks after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_in | input | 3 | Raw Hall sensor lines |
| dir_rev | input | 1 | Reverse rotation when high |
| pwm_on | input | 1 | Chopping control; high drives the selected pair |
| slow_decay | input | 1 | High selects slow decay, low selects fast decay |
| sync_rect | input | 1 | High enables synchronous rectification |
| brake_n | input | 1 | Low requests braking |
| disable_in | input | 1 | High forces all gates off (highest priority) |
| coast_req | input | 1 | High forces all gates off (from fault logic) |
| gate_hi | output | 3 | High-side gate enables, phases A..C |
| gate_lo | output | 3 | Low-side gate enables, phases A..C |
| hall_bad | output | 1 | Invalid Hall code flag |
| tach_pulse | output | 1 | Speed pulse on each Hall change |

## Verification
The six Hall codes are stepped through in both directions with PWM held high. Each code has to select a different source and sink pair, so this pass exposes any swapped table entry or any fault in the direction swap. PWM is then toggled under all four combinations of decay mode and synchronous rectification. These four runs tell apart which switches open and which complements close, and they show the dead-time gap before each complement turns on. Finally, brake, coast, invalid codes and disable are applied on top of one another to confirm the priority order. A single late Hall change is timed to measure both the synchronizer latency and the full width of the tach pulse.

// File: rtl/bldc_pkg.sv
`timescale 1ns/1ps
package bldc_pkg;

   typedef struct packed {
      logic       valid;
      logic [1:0] src;   // phase driven high
      logic [1:0] snk;   // phase driven low
   } comm_sel_t;

   typedef struct packed {
      logic [2:0] hi;
      logic [2:0] lo;
   } gate_req_t;

   function automatic comm_sel_t hall_to_sel(input logic [2:0] code, input logic rev);
      comm_sel_t s;
      s.valid = 1'b1;
      unique case (code)
         3'b101:  begin s.src = 2'd0; s.snk = 2'd1; end
         3'b100:  begin s.src = 2'd0; s.snk = 2'd2; end
         3'b110:  begin s.src = 2'd1; s.snk = 2'd2; end
         3'b010:  begin s.src = 2'd1; s.snk = 2'd0; end
         3'b011:  begin s.src = 2'd2; s.snk = 2'd0; end
         3'b001:  begin s.src = 2'd2; s.snk = 2'd1; end
         default: begin s.src = 2'd0; s.snk = 2'd0; s.valid = 1'b0; end
      endcase
      if (rev) begin
         logic [1:0] t;
         t     = s.src;
         s.src = s.snk;
         s.snk = t;
      end
      return s;
   endfunction

endpackage

// File: rtl/hall_input_sync.sv
`timescale 1ns/1ps
module hall_input_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_depth
      $error("hall_input_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hall_input_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_in};
   end

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/tach_pulse_gen.sv
`timescale 1ns/1ps
module tach_pulse_gen #(
   parameter int W   = 3,
   parameter int CYC = 600
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level_in,
   output logic         pulse_out
);
   if (CYC < 1) begin : g_bad_cyc
      $error("tach_pulse_gen: CYC must be at least 1");
   end

   localparam int CW = $clog2(CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYC);

   logic [W-1:0]  prev_q;
   logic [CW-1:0] left_q;
   logic          change;

   assign change = (level_in != prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         left_q <= '0;
      end else begin
         prev_q <= level_in;
         if (change)              left_q <= LOAD;
         else if (left_q != '0)   left_q <= left_q - 1'b1;
      end
   end

   assign pulse_out = (left_q != '0);

   // R10
   tach_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_in != $past(level_in)) |=> pulse_out);
endmodule

// File: rtl/phase_gate_guard.sv
`timescale 1ns/1ps
module phase_gate_guard #(
   parameter int DEAD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want_hi,
   input  logic want_lo,
   output logic gate_hi,
   output logic gate_lo
);
   if (DEAD < 0) begin : g_bad_dead
      $error("phase_gate_guard: DEAD must not be negative");
   end

   if (DEAD == 0) begin : g_interlock_only
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
         end else begin
            gate_hi <= want_hi & ~want_lo & (gate_hi | ~gate_lo);
            gate_lo <= want_lo & ~want_hi & (gate_lo | ~gate_hi);
         end
      end
   end else begin : g_dead_counter
      localparam int CW = $clog2(DEAD + 1);
      localparam logic [CW-1:0] DMAX = CW'(DEAD);
      logic [CW-1:0] idle_q;
      logic          ready;

      assign ready = (idle_q == DMAX);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
            idle_q  <= '0;
         end else begin
            gate_hi <= want_hi & (gate_hi | (~gate_lo & ready));
            gate_lo <= want_lo & (gate_lo | (~gate_hi & ready));
            if (gate_hi | gate_lo) idle_q <= '0;
            else if (!ready)       idle_q <= idle_q + 1'b1;
         end
      end
   end

   // R9
   no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));
   // R9
   hi_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi) |-> !$past(gate_lo));
   // R9
   lo_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo) |-> !$past(gate_hi));
endmodule

// File: rtl/bldc_commutator.sv
`timescale 1ns/1ps
module bldc_commutator
   import bldc_pkg::*;
#(
   parameter int CLK_MHZ     = 200,
   parameter int TACH_NS     = 3000,
   parameter int DEAD_CYC    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] hall_in,
   input  logic       dir_rev,
   input  logic       pwm_on,
   input  logic       slow_decay,
   input  logic       sync_rect,
   input  logic       brake_n,
   input  logic       disable_in,
   input  logic       coast_req,
   output logic [2:0] gate_hi,
   output logic [2:0] gate_lo,
   output logic       hall_bad,
   output logic       tach_pulse
);
   localparam int TACH_CYC = CLK_MHZ * TACH_NS / 1000;
   localparam int PHASES   = 3;

   if (TACH_CYC < 1) begin : g_bad_tach
      $error("bldc_commutator: tach width rounds to zero clocks");
   end

   logic [2:0] hall_s;
   comm_sel_t  sel;
   gate_req_t  want;

   hall_input_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(hall_in), .sync_out(hall_s));

   tach_pulse_gen #(.W(3), .CYC(TACH_CYC)) u_tach (
      .clk(clk), .rst_n(rst_n), .level_in(hall_s), .pulse_out(tach_pulse));

   assign sel = hall_to_sel(hall_s, dir_rev);

   always_comb begin
      want = '0;
      if (disable_in || coast_req || !sel.valid) begin
         want = '0;
      end else if (!brake_n) begin
         want.lo = '1;
      end else if (pwm_on) begin
         want.hi[sel.src] = 1'b1;
         want.lo[sel.snk] = 1'b1;
      end else if (slow_decay) begin
         want.lo[sel.snk] = 1'b1;
         if (sync_rect) want.lo[sel.src] = 1'b1;
      end else if (sync_rect) begin
         want.lo[sel.src] = 1'b1;
         want.hi[sel.snk] = 1'b1;
      end
   end

   for (genvar p = 0; p < PHASES; p++) begin : g_phase
      phase_gate_guard #(.DEAD(DEAD_CYC)) u_guard (
         .clk(clk), .rst_n(rst_n),
         .want_hi(want.hi[p]), .want_lo(want.lo[p]),
         .gate_hi(gate_hi[p]), .gate_lo(gate_lo[p]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hall_bad <= 1'b0;
      else        hall_bad <= !sel.valid;
   end

   // R1
   disable_coast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disable_in |=> (gate_hi == 3'b000 && gate_lo == 3'b000));
   // R2
   bad_code_coast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hall_bad |-> (gate_hi == 3'b000 && gate_lo == 3'b000));
   // R2
   coast_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coast_req |=> (gate_hi == 3'b000 && gate_lo == 3'b000));
   // R3
   brake_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!brake_n && !disable_in) |=> (gate_hi == 3'b000));
endmodule

// File: tb/sim_bldc_commutator.sv
`timescale 1ns/1ps
module sim_bldc_commutator;
   localparam int DEAD = 4;
   localparam int TACH = 600;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hall_in = 3'b101;
   logic       dir_rev = 1'b0, pwm_on = 1'b1, slow_decay = 1'b1, sync_rect = 1'b0;
   logic       brake_n = 1'b1, disable_in = 1'b0, coast_req = 1'b0;
   logic [2:0] gate_hi, gate_lo;
   logic       hall_bad, tach_pulse;

   int checks = 0;
   int errors = 0;
   string tag = "R1";
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bldc_commutator #(.CLK_MHZ(200), .TACH_NS(3000), .DEAD_CYC(DEAD), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir_rev(dir_rev), .pwm_on(pwm_on),
      .slow_decay(slow_decay), .sync_rect(sync_rect), .brake_n(brake_n),
      .disable_in(disable_in), .coast_req(coast_req), .gate_hi(gate_hi),
      .gate_lo(gate_lo), .hall_bad(hall_bad), .tach_pulse(tach_pulse));

   // reference model state
   int m_s1, m_s2, m_prev, m_tcnt, m_bad;
   int mhi[3], mlo[3], mcnt[3];
   int seq[6] = '{5, 4, 6, 2, 3, 1};

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_tcnt = 0; m_bad = 0;
         for (int p = 0; p < 3; p++) begin mhi[p] = 0; mlo[p] = 0; mcnt[p] = 0; end
      end else begin
         int wh[3], wl[3], k, src, snk, t, nh, nl;
         k = -1;
         for (int i = 0; i < 6; i++) if (seq[i] == m_s2) k = i;
         for (int p = 0; p < 3; p++) begin wh[p] = 0; wl[p] = 0; end
         src = k / 2;
         snk = ((k + 1) / 2 + 1) % 3;
         if (dir_rev) begin t = src; src = snk; snk = t; end
         if (disable_in || coast_req || k < 0) begin
         end else if (!brake_n) begin
            for (int p = 0; p < 3; p++) wl[p] = 1;
         end else if (pwm_on) begin
            wh[src] = 1; wl[snk] = 1;
         end else if (slow_decay) begin
            wl[snk] = 1;
            if (sync_rect) wl[src] = 1;
         end else if (sync_rect) begin
            wl[src] = 1; wh[snk] = 1;
         end
         for (int p = 0; p < 3; p++) begin
            nh = (wh[p] && (mhi[p] || (!mlo[p] && mcnt[p] == DEAD))) ? 1 : 0;
            nl = (wl[p] && (mlo[p] || (!mhi[p] && mcnt[p] == DEAD))) ? 1 : 0;
            if (mhi[p] || mlo[p]) mcnt[p] = 0;
            else if (mcnt[p] < DEAD) mcnt[p] = mcnt[p] + 1;
            mhi[p] = nh; mlo[p] = nl;
         end
         if (m_s2 != m_prev) m_tcnt = TACH;
         else if (m_tcnt > 0) m_tcnt = m_tcnt - 1;
         m_bad = (k < 0) ? 1 : 0;
         m_prev = m_s2;
         m_s2 = m_s1;
         m_s1 = int'(hall_in);
      end
   end

   // compare on every clock, 1 ns after the edge
   always @(posedge clk) begin
      #1;
      if (!done) begin
         logic [2:0] eh, el;
         for (int p = 0; p < 3; p++) begin eh[p] = mhi[p][0]; el[p] = mlo[p][0]; end
         checks++;
         if (gate_hi !== eh || gate_lo !== el || hall_bad !== m_bad[0] ||
             tach_pulse !== (m_tcnt > 0)) begin
            errors++;
            $display("FAIL %s t=%0t hi=%b lo=%b bad=%b tach=%b exp hi=%b lo=%b bad=%0d tach=%0d",
                     tag, $time, gate_hi, gate_lo, hall_bad, tach_pulse, eh, el, m_bad, m_tcnt > 0);
         end
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_dir(input string t, input bit cond, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
      end
   endtask

   task automatic chop(input int n);
      for (int i = 0; i < n; i++) begin
         pwm_on = 1'b0; wait_cyc(12);
         pwm_on = 1'b1; wait_cyc(12);
      end
   endtask

   initial begin
      // reset state
      wait_cyc(4);
      check_dir("R1 reset gates off", gate_hi == 0 && gate_lo == 0 && !tach_pulse && !hall_bad,
                int'({gate_hi, gate_lo}), 0);
      rst_n = 1'b1;
      wait_cyc(12);

      tag = "R4 forward table";
      for (int i = 0; i < 6; i++) begin hall_in = 3'(seq[i]); wait_cyc(12); end
      tag = "R5 reverse table";
      dir_rev = 1'b1;
      for (int i = 0; i < 6; i++) begin hall_in = 3'(seq[i]); wait_cyc(12); end
      dir_rev = 1'b0;

      tag = "R6 slow decay";
      slow_decay = 1'b1; sync_rect = 1'b0;
      hall_in = 3'b110; chop(3);
      tag = "R7 fast decay";
      slow_decay = 1'b0; chop(3);
      tag = "R8 R9 slow decay sync rect";
      slow_decay = 1'b1; sync_rect = 1'b1; hall_in = 3'b011; chop(3);
      tag = "R8 R9 fast decay sync rect";
      slow_decay = 1'b0; chop(3);
      dir_rev = 1'b1; chop(2); dir_rev = 1'b0;
      slow_decay = 1'b1; sync_rect = 1'b0;

      tag = "R3 brake";
      brake_n = 1'b0; wait_cyc(15);
      tag = "R1 disable over brake";
      disable_in = 1'b1; wait_cyc(10);
      check_dir("R1 disable overrides brake", gate_hi == 0 && gate_lo == 0,
                int'({gate_hi, gate_lo}), 0);
      disable_in = 1'b0; wait_cyc(10);
      brake_n = 1'b1; wait_cyc(12);

      tag = "R2 coast request";
      coast_req = 1'b1; wait_cyc(8);
      brake_n = 1'b0; wait_cyc(8);
      brake_n = 1'b1; coast_req = 1'b0; wait_cyc(12);
      tag = "R2 invalid code";
      hall_in = 3'b000; wait_cyc(8);
      check_dir("R2 code 000 flagged", hall_bad == 1'b1, int'(hall_bad), 1);
      hall_in = 3'b111; brake_n = 1'b0; wait_cyc(8);
      check_dir("R2 code 111 coasts over brake", gate_lo == 0, int'(gate_lo), 0);
      brake_n = 1'b1; hall_in = 3'b101; wait_cyc(12);

      // latency and tach width: settle first
      tag = "R11 R10 latency and tach";
      wait_cyc(TACH + 20);
      check_dir("R10 tach idle after pulse", tach_pulse == 1'b0, int'(tach_pulse), 0);
      hall_in = 3'b100;   // lo moves from B to C
      @(posedge clk); @(posedge clk); #1;
      check_dir("R11 low B still on after two clocks", gate_lo[1] == 1'b1, int'(gate_lo[1]), 1);
      @(posedge clk); #1;
      check_dir("R11 low B off after three clocks", gate_lo[1] == 1'b0, int'(gate_lo[1]), 0);
      begin
         int w;
         w = 1;
         while (tach_pulse && w < TACH + 10) begin @(posedge clk); #1; if (tach_pulse) w++; end
         check_dir("R10 tach pulse width", w == TACH, w, TACH);
      end
      wait_cyc(10);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(5ns * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule